// File: doc/BRIEF.md
# Three-wire serial control port receiver

This block is the device side of a three-wire control interface. The interface has a shift clock line, a data line and a latch strobe line. All three lines are sampled in the system-clock domain through two-flop synchronizers, and edges are detected from the synchronized samples. On each rising edge of the shift clock, the block appends the data line to a 16-bit shift register, most significant bit first. A rising edge on the strobe copies the shift register into the parallel control word. A one-cycle write pulse marks each such copy.

After the external reset is released, or after power-up, a 1024-clock initialization window runs. No control-word update is accepted during this window. The shift register itself has no reset, so it keeps collecting bits during reset and during the window. A strobe rise that arrives after the window therefore latches whatever bits were shifted in, including bits shifted before or during reset.

The strobe may rest high or low between words. Words may be sent back to back or one at a time. The only condition is that a rising strobe edge follows the last bit of the word.

Top module: `ctl_port_rx`

## Requirements
- R1: Each rising edge of `sclk_i` shifts `sdata_i` into bit 0 of the shift register while the older bits move one place toward bit 15. After any number of shift clocks, the shift register holds the last 16 bits received, with the first of them in bit 15.
- R2: When the window is complete, a rising edge of `strobe_i` loads the shift register into `ctl_word_o`. The update appears 3 system clocks after the pin edge. If a shift-clock rise is detected in the same cycle as the strobe rise, the load uses the contents from before that shift.
- R3: While `rst_n` is low, `ctl_word_o` is 16'h0000, and `wr_pulse_o` and `ready_o` are 0.
- R4: `ready_o` goes high exactly 1024 system clocks after `rst_n` goes high. It stays high until the next reset.
- R5: A strobe rise that is detected while `ready_o` is low changes neither `ctl_word_o` nor `wr_pulse_o`.
- R6: Reset does not clear the shift register. Bits shifted in while reset is low, or during the window, are kept and can be latched once the window is complete.
- R7: A word is accepted whether the strobe rests high (low pulse, then rise) or rests low (rise after the word). Words may follow each other with no idle gap.
- R8: Asserting `rst_n` again at any time clears `ctl_word_o` and restarts the 1024-clock window from zero.
- R9: `wr_pulse_o` is high for exactly one cycle per accepted update, in the cycle in which `ctl_word_o` takes its new value. `ctl_word_o` never changes in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous external reset |
| sclk_i | input | 1 | Serial shift clock pin |
| strobe_i | input | 1 | Latch strobe pin |
| sdata_i | input | 1 | Serial data pin |
| ctl_word_o | output | 16 | Parallel control word |
| wr_pulse_o | output | 1 | One-cycle pulse on each accepted update |
| ready_o | output | 1 | High once the initialization window is complete |

## Verification
The bench aims at the following corner cases. Each is listed with the symptom a faulty design would show.

- **Window boundary.** The bench samples `ready_o` at 1023 and at 1024 clocks after release. An off-by-one counter fails one of the two samples.
- **Words split across reset.** The bench sends part of a word while reset is held, then latches it after the window. A design that clears the shift register, or freezes it during reset, latches a wrong value.
- **Strobe rise inside the window.** The bench sends one. A design that does not gate the load writes the word early and pulses `wr_pulse_o`.
- **Random traffic.** Random words use both strobe resting levels, prefixes of extra bits and back-to-back framing. A design with reversed bit order, a wrong edge polarity or a lost first bit produces mismatching words or pulse counts.

// File: rtl/ctl_port_rx.sv
module ctl_port_rx #(
  parameter int WORD_W      = 16,
  parameter int INIT_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              strobe_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] ctl_word_o,
  output logic              wr_pulse_o,
  output logic              ready_o
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INIT_CYCLES);

  logic [SYNC_STAGES-1:0] sclk_q, strb_q, sdat_q;
  logic                   sclk_d, strb_d;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       init_cnt;

  always_ff @(posedge clk) begin
    sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk_i};
    strb_q <= {strb_q[SYNC_STAGES-2:0], strobe_i};
    sdat_q <= {sdat_q[SYNC_STAGES-2:0], sdata_i};
    sclk_d <= sclk_q[SYNC_STAGES-1];
    strb_d <= strb_q[SYNC_STAGES-1];
  end

  wire sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_d;
  wire strb_rise = strb_q[SYNC_STAGES-1] & ~strb_d;

  always_ff @(posedge clk)
    if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_q[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 init_cnt <= '0;
    else if (init_cnt != CNT_END) init_cnt <= init_cnt + 1'b1;

  assign ready_o = (init_cnt == CNT_END);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_word_o <= '0;
      wr_pulse_o <= 1'b0;
    end else begin
      wr_pulse_o <= strb_rise & ready_o;
      if (strb_rise & ready_o) ctl_word_o <= shreg;
    end
endmodule

module ctl_port_rx_chk #(
  parameter int WORD_W      = 16,
  parameter int INIT_CYCLES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] ctl_word_o,
  input logic              wr_pulse_o,
  input logic              ready_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1) + 1;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != CW'(INIT_CYCLES)) cyc <= cyc + 1'b1;

  p_reset_state_r3: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (ctl_word_o == '0 && !wr_pulse_o && !ready_o)));
  p_ready_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> cyc == CW'(INIT_CYCLES));
  p_ready_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> cyc != CW'(INIT_CYCLES));
  p_ready_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  p_no_write_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> !wr_pulse_o);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |=> !wr_pulse_o);
  p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse_o |-> $stable(ctl_word_o));
endmodule

bind ctl_port_rx ctl_port_rx_chk #(.WORD_W(WORD_W), .INIT_CYCLES(INIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_word_o(ctl_word_o),
  .wr_pulse_o(wr_pulse_o), .ready_o(ready_o));

// File: tb/sim_ctl_port_rx.sv
`timescale 1ns/1ps
module sim_ctl_port_rx;
  localparam int P = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, strobe = 1'b0, sdata = 1'b0;
  logic [15:0] ctl_word;
  logic wr_pulse, ready;
  logic [15:0] mshift = '0, exp_word = '0;
  int exp_cnt = 0, npulse = 0, nchk = 0, nfail = 0;
  bit model_ready = 0, done = 0;

  always #4 clk = ~clk;

  ctl_port_rx u0 (.clk(clk), .rst_n(rst_n), .sclk_i(sclk), .strobe_i(strobe),
    .sdata_i(sdata), .ctl_word_o(ctl_word), .wr_pulse_o(wr_pulse), .ready_o(ready));

  always @(negedge clk) if (wr_pulse) npulse++;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] shifted(input logic [15:0] s, input logic b);
    return {s[14:0], b};
  endfunction

  task automatic shift_bit(input logic b);
    sdata = b; tick(P);
    sclk = 1'b1; mshift = shifted(mshift, b); tick(P);
    sclk = 1'b0;
  endtask

  task automatic set_strobe(input logic v);
    if (!strobe && v && model_ready) begin exp_word = mshift; exp_cnt++; end
    strobe = v; tick(P);
  endtask

  task automatic send_word(input logic [15:0] w, input bit idle_high, input int extra);
    set_strobe(idle_high);
    for (int i = 0; i < extra; i++) shift_bit(1'($urandom));
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    if (idle_high) begin set_strobe(1'b0); set_strobe(1'b1); end
    else set_strobe(1'b1);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    check("R3 word", ctl_word, 0);
    check("R3 pulse", wr_pulse, 0);
    check("R3 ready", ready, 0);

    // R4 exact window
    rst_n = 1'b1;
    tick(1023);
    check("R4 ready at 1023", ready, 0);
    tick(1);
    check("R4 ready at 1024", ready, 1);
    model_ready = 1;

    // R6 word split across reset, R5 strobe rise in window ignored
    rst_n = 1'b0; model_ready = 0;
    exp_word = 16'h0; strobe = 1'b0;
    tick(2);
    for (int i = 15; i >= 8; i--) shift_bit(1'(16'hA5C3 >> i));
    rst_n = 1'b1;
    for (int i = 7; i >= 0; i--) shift_bit(1'(16'hA5C3 >> i));
    set_strobe(1'b1);
    tick(6);
    check("R5 word unchanged in window", ctl_word, 16'h0000);
    check("R5 no pulse in window", npulse, exp_cnt);
    check("R5 ready still low", ready, 0);
    tick(1100);
    model_ready = 1;
    set_strobe(1'b0);
    set_strobe(1'b1);
    tick(6);
    check("R6 word kept across reset", ctl_word, 16'hA5C3);
    check("R9 one pulse", npulse, exp_cnt);

    // R1 R2 R7 random traffic, mixed idle level, prefixes, back to back
    for (int n = 0; n < 40; n++) begin
      logic [15:0] w = 16'($urandom);
      bit ih = 1'($urandom);
      int ex = $urandom % 5;
      if (n == 0) w = 16'h8000;
      if (n == 1) w = 16'h0001;
      if (n == 2) w = 16'hFFFF;
      send_word(w, ih, ex);
      if ($urandom % 2) tick(6);
      check(ih ? "R7 idle-high word" : "R2 idle-low word", ctl_word, exp_word);
      check("R1 model match", exp_word, w);
      check("R9 pulse count", npulse, exp_cnt);
    end

    // R8 reset mid-operation restarts window
    shift_bit(1'b1);
    rst_n = 1'b0; model_ready = 0;
    tick(2);
    check("R8 word cleared", ctl_word, 0);
    check("R8 ready cleared", ready, 0);
    strobe = 1'b0;
    rst_n = 1'b1;
    tick(1023);
    check("R8 ready at 1023", ready, 0);
    tick(1);
    check("R8 ready at 1024", ready, 1);
    tick(4);
    summary();
  end
endmodule